// File: doc/BRIEF.md
# Breakpoint Address Matcher

This block sits beside a CPU and watches every address it places on its 24-bit bus. Two independent comparators each hold a programmable match address, an enable bit and an option that ignores the low address byte. With that option set, the comparator matches any address in a 256-byte page. When an enabled comparator hits, the block raises a sticky break request. The CPU uses this request to stop at an instruction boundary.

A hit on the first byte of an instruction raises the request at once, so the CPU stops before it runs that instruction. A hit on any later byte of an instruction is held as pending. It becomes a break request only when the CPU reports that the current instruction has finished. The request stays raised until a debugger writes 0 to it. That write also discards any pending hit and the per-comparator hit status bits. A debugger can also write 1 to force a break.

The block never stalls the CPU and has no back-pressure. The bus address is qualified by a valid strobe, and every valid cycle is observed. Configuration uses a plain single-cycle write port, so every write is accepted in the cycle it is presented.

Top module: `brkpt_watch`

## Requirements
- R1: After reset, the break request, both hit status bits, every match byte, both enable bits and both ignore-low bits are 0, and no bus address can cause a break until a comparator is enabled.
- R2: With ignore-low clear, an enabled comparator matches only when all 24 address bits equal its stored upper, high and low bytes.
- R3: With ignore-low set, only address bits 23:8 are compared, and any value of bits 7:0 matches.
- R4: A comparator whose enable bit is 0 never causes a break and never sets its hit status bit.
- R5: A hit while cpu_first_fetch is 1 raises brk_next at the next clock edge.
- R6: A hit while cpu_first_fetch is 0 is held as pending. brk_next rises at the clock edge of the next cycle with cpu_instr_done at 1, and not before.
- R7: Once raised, brk_next stays at 1 through any bus activity until the debugger writes 0 to the break register.
- R8: A write of 0 to the break register (cfg_addr 8, data bit 0) clears brk_next, any pending hit and both hit status bits.
- R9: A write of 1 to the break register raises brk_next without any hit and leaves the status bits unchanged.
- R10: A hit on both comparators in the same cycle gives one break request and sets both status bits. hit_status bit n is set only by comparator n.
- R11: Addresses presented while cpu_addr_valid is 0 cause no hit.
- R12: Register map: comparator n uses cfg_addr 4n (low byte), 4n+1 (high byte), 4n+2 (upper byte) and 4n+3 (control: bit 0 enable, bit 1 ignore-low). A write takes effect at the clock edge on which cfg_we is sampled at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_addr_valid | input | 1 | CPU address is valid this cycle |
| cpu_addr | input | 24 | CPU address bus |
| cpu_first_fetch | input | 1 | Address is the first byte of an instruction |
| cpu_instr_done | input | 1 | Current instruction completes this cycle |
| brk_next | output | 1 | Sticky break request |
| hit_status | output | 2 | Per-comparator hit status, bit n for comparator n |

## Verification
A table of configuration and probe pairs checks the comparator on one comparator. The pairs cover an exact hit, a single differing byte at each of the three byte positions, page-mode probes at both ends of the page, a page-mode miss in the high byte and in bit 23, and a disabled exact hit. Together these separate a full compare from a masked one and a wrong mask width from a correct one. Directed sequences then separate an immediate break from a deferred one. They check that a pending hit dies on release and that a forced break differs from a real hit. A double hit is checked against one hit on each comparator, so crossed or merged status bits show up. An invalid-strobe probe confirms that addresses are qualified by the valid strobe.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  localparam int ADDR_W     = 24;
  localparam int BYTE_W     = 8;
  localparam int NUM_CMP    = 2;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int SLOT       = 4;                    // registers per comparator
  localparam int FLAG_REG   = NUM_CMP * SLOT;       // break register index
  localparam int REG_AW     = $clog2(FLAG_REG + 1);

  typedef struct packed {
    logic              en;
    logic              ign_low;
    logic [ADDR_W-1:0] addr;
  } cmp_cfg_t;
endpackage

// File: rtl/brkpt_cfg_regs.sv
module brkpt_cfg_regs
  import brkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output cmp_cfg_t          cfg [NUM_CMP],
  output logic              flag_wr,
  output logic              flag_val
);
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
    cmp_cfg_t cfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (we) begin
        for (int k = 0; k < ADDR_BYTES; k++) begin
          if (addr == REG_AW'(g*SLOT + k))
            cfg_q.addr[k*BYTE_W +: BYTE_W] <= wdata;
        end
        if (addr == REG_AW'(g*SLOT + SLOT - 1)) begin
          cfg_q.en      <= wdata[0];
          cfg_q.ign_low <= wdata[1];
        end
      end
    end
    assign cfg[g] = cfg_q;
  end

  assign flag_wr  = we && (addr == REG_AW'(FLAG_REG));
  assign flag_val = wdata[0];
endmodule

// File: rtl/brkpt_comparator.sv
module brkpt_comparator
  import brkpt_pkg::*;
(
  input  cmp_cfg_t          cfg,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};

  logic [ADDR_W-1:0] care;
  assign care = cfg.ign_low ? PAGE_MASK : '1;
  assign hit  = valid && cfg.en && (((addr ^ cfg.addr) & care) == '0);
endmodule

// File: rtl/brkpt_flag.sv
module brkpt_flag
  import brkpt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] hit,
  input  logic               first,
  input  logic               done,
  input  logic               flag_wr,
  input  logic               flag_val,
  output logic               brk_next,
  output logic [NUM_CMP-1:0] status
);
  logic               pending, pend_d, brk_d;
  logic [NUM_CMP-1:0] stat_d;
  logic               any_hit;

  assign any_hit = |hit;

  always_comb begin
    pend_d = pending | (any_hit & ~first);
    brk_d  = brk_next;
    stat_d = status | hit;
    if (any_hit && first) brk_d = 1'b1;
    if (done) begin
      if (pend_d) brk_d = 1'b1;
      pend_d = 1'b0;
    end
    if (flag_wr) begin
      brk_d = flag_val;
      if (!flag_val) begin
        pend_d = 1'b0;
        stat_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      brk_next <= 1'b0;
      status   <= '0;
    end else begin
      pending  <= pend_d;
      brk_next <= brk_d;
      status   <= stat_d;
    end
  end

  assert_first_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && first && !flag_wr) |=> brk_next);
  assert_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_next && !(flag_wr && flag_val) && !(any_hit && first) &&
     !(done && (pending || any_hit))) |=> !brk_next);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_next && !flag_wr) |=> brk_next);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_val) |=> (!brk_next && !pending && status == '0));
  assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_val) |=> brk_next);
endmodule

// File: rtl/brkpt_watch.sv
module brkpt_watch
  import brkpt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0]  cfg_wdata,
  input  logic               cpu_addr_valid,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_first_fetch,
  input  logic               cpu_instr_done,
  output logic               brk_next,
  output logic [NUM_CMP-1:0] hit_status
);
  cmp_cfg_t           cfg [NUM_CMP];
  logic               flag_wr, flag_val;
  logic [NUM_CMP-1:0] hit;

  brkpt_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(cfg), .flag_wr(flag_wr), .flag_val(flag_val)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    brkpt_comparator u_cmp (
      .cfg(cfg[g]), .valid(cpu_addr_valid), .addr(cpu_addr), .hit(hit[g])
    );
    // R4 R10: a status bit rises only if its own comparator was enabled
    assert_status_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_status[g]) |-> $past(cfg[g].en));
  end

  brkpt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .first(cpu_first_fetch),
    .done(cpu_instr_done), .flag_wr(flag_wr), .flag_val(flag_val),
    .brk_next(brk_next), .status(hit_status)
  );

  // R11: with no valid address, no status bit can rise
  assert_valid_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_addr_valid && !flag_wr) |=> $stable(hit_status));
endmodule

// File: tb/test_brkpt_watch.sv
`timescale 1ns/1ps
module test_brkpt_watch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cpu_addr_valid = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_first_fetch = 1'b0;
  logic        cpu_instr_done = 1'b0;
  logic        brk_next;
  logic [1:0]  hit_status;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  brkpt_watch i_brkpt_watch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_addr_valid(cpu_addr_valid), .cpu_addr(cpu_addr),
    .cpu_first_fetch(cpu_first_fetch), .cpu_instr_done(cpu_instr_done),
    .brk_next(brk_next), .hit_status(hit_status)
  );

  // {match addr, enable, ignore-low, probe addr, expected break}
  localparam int NV = 9;
  localparam logic [50:0] VEC [NV] = '{
    {24'h123456, 1'b1, 1'b0, 24'h123456, 1'b1},  // R2 exact
    {24'h123456, 1'b1, 1'b0, 24'h123457, 1'b0},  // R2 low byte differs
    {24'h123456, 1'b1, 1'b0, 24'h123556, 1'b0},  // R2 high byte differs
    {24'h123456, 1'b1, 1'b0, 24'h133456, 1'b0},  // R2 upper byte differs
    {24'h123456, 1'b1, 1'b1, 24'h1234FF, 1'b1},  // R3 page top
    {24'h123456, 1'b1, 1'b1, 24'h123400, 1'b1},  // R3 page bottom
    {24'h123456, 1'b1, 1'b1, 24'h123556, 1'b0},  // R3 high byte differs
    {24'h123456, 1'b1, 1'b1, 24'h923456, 1'b0},  // R3 bit 23 differs
    {24'h123456, 1'b0, 1'b0, 24'h123456, 1'b0}   // R4 disabled
  };

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(logic v, logic [23:0] a, logic first, logic done);
    @(negedge clk);
    cpu_addr_valid = v; cpu_addr = a; cpu_first_fetch = first; cpu_instr_done = done;
    @(negedge clk);
    cpu_addr_valid = 1'b0; cpu_first_fetch = 1'b0; cpu_instr_done = 1'b0;
  endtask

  task automatic set_cmp(int n, logic [23:0] a, logic en, logic ign);
    wr(4*n + 0, a[7:0]);
    wr(4*n + 1, a[15:8]);
    wr(4*n + 2, a[23:16]);
    wr(4*n + 3, {6'b0, ign, en});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] ca, pa;
    logic ce, ci, pe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 brk_next after reset", brk_next, 0);
    check("R1 hit_status after reset", hit_status, 0);
    bus(1'b1, 24'h000000, 1'b1, 1'b0);
    check("R1 cleared config gives no break", brk_next, 0);

    for (int i = 0; i < NV; i++) begin
      {ca, ce, ci, pa, pe} = VEC[i];
      wr(8, 0);
      set_cmp(0, ca, ce, ci);
      bus(1'b1, pa, 1'b1, 1'b0);
      check($sformatf("vector %0d (R2 R3 R4 R12)", i), brk_next, pe);
      if (!ce) check("R4 disabled status", hit_status, 0);
    end

    // R5 / R12: comparator 1 immediate break on first fetch
    wr(8, 0);
    set_cmp(0, 24'h000000, 1'b0, 1'b0);
    set_cmp(1, 24'hABCDEF, 1'b1, 1'b0);
    bus(1'b1, 24'hABCDEF, 1'b1, 1'b0);
    check("R5 immediate break", brk_next, 1);
    check("R12 comparator 1 status bit", hit_status, 2'b10);

    // R7 sticky through activity
    bus(1'b1, 24'h000111, 1'b1, 1'b1);
    bus(1'b0, 24'h000000, 1'b0, 1'b1);
    check("R7 break stays set", brk_next, 1);

    // R8 release
    wr(8, 0);
    check("R8 release clears break", brk_next, 0);
    check("R8 release clears status", hit_status, 0);

    // R6 deferred break
    bus(1'b1, 24'hABCDEF, 1'b0, 1'b0);
    check("R6 no break mid-instruction", brk_next, 0);
    bus(1'b1, 24'h000222, 1'b0, 1'b0);
    check("R6 still pending", brk_next, 0);
    bus(1'b0, 24'h000000, 1'b0, 1'b1);
    check("R6 break at instruction end", brk_next, 1);

    // R8 pending discarded by release
    wr(8, 0);
    bus(1'b1, 24'hABCDEF, 1'b0, 1'b0);
    wr(8, 0);
    bus(1'b0, 24'h000000, 1'b0, 1'b1);
    check("R8 pending discarded", brk_next, 0);

    // R9 forced break
    wr(8, 1);
    check("R9 forced break", brk_next, 1);
    check("R9 status untouched", hit_status, 0);
    wr(8, 0);

    // R10 double hit, then single hit on comparator 0
    set_cmp(0, 24'hABCD00, 1'b1, 1'b1);
    bus(1'b1, 24'hABCDEF, 1'b1, 1'b0);
    check("R10 one break on double hit", brk_next, 1);
    check("R10 both status bits", hit_status, 2'b11);
    wr(8, 0);
    bus(1'b1, 24'hABCD10, 1'b1, 1'b0);
    check("R10 comparator 0 only", hit_status, 2'b01);
    wr(8, 0);

    // R11 invalid strobe
    bus(1'b0, 24'hABCDEF, 1'b1, 1'b0);
    check("R11 invalid address ignored", brk_next, 0);
    check("R11 invalid address status", hit_status, 0);

    finish_run();
  end
endmodule